// File: doc/BRIEF.md
# Input Cell Buffer with Per-Output Queues

This block sits at one input of an N-port cell switch. It stores fixed-size cells that arrive from upstream, where packets are split into cells before they reach the block. It files each cell into a logical queue chosen by the cell's destination output. All queues share one cell memory. Each queue is a linked list that runs from a head pointer to a tail pointer. A free list holds the unused cell slots and is filled at reset.

The block exports a bitmap that shows which queues hold cells. A fabric scheduler reads the bitmap and grants one queue at a time. The granted queue's head cell appears on the dequeue outputs in the same cycle as the grant, and the cell is removed at the next clock edge. Because each output has its own queue, a cell waiting for a busy output never holds back cells bound for other outputs. When every slot is in use, the block lowers its ready signal toward upstream instead of dropping cells.

Top module: `voq_input_buffer`

## Requirements
- R1: After reset every queue is empty. `nonempty_o` is 0, `enq_ready_o` is 1, `err_o` is 0 and `deq_valid_o` is 0.
- R2: Cells leave each queue in the order they were accepted into that queue.
- R3: A grant for queue q returns the head cell of queue q, whatever the other queues hold. A cell waiting in one queue never blocks a dequeue from another queue.
- R4: `enq_ready_o` is 0 exactly when all DEPTH slots hold cells. An enqueue offered while `enq_ready_o` is 0 is not stored.
- R5: Bit q of `nonempty_o` is 1 exactly when queue q holds at least one cell. The bit changes in the cycle that follows the clock edge that changes the queue's occupancy.
- R6: A grant to an empty queue gives `deq_valid_o` = 0 and leaves every queue unchanged. It also sets `err_o`, which stays at 1 until reset.
- R7: An enqueue and a dequeue can be accepted in the same cycle, also on the same queue and also when that queue holds exactly one cell. When the buffer is full, a dequeue in a cycle does not let an enqueue in that same cycle be accepted.
- R8: During a grant to a non-empty queue, `deq_valid_o` is 1 and `deq_data_o` carries that queue's head cell in the same cycle. The cell is removed at the next rising edge.
- R9: Slots are shared by all queues, so a single queue can hold all DEPTH cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Cell offered by upstream |
| enq_dest_i | input | $clog2(N_PORTS) | Destination output of the offered cell |
| enq_data_i | input | CELL_W | Offered cell |
| enq_ready_o | output | 1 | Slot available; low means backpressure |
| deq_valid_i | input | 1 | Dequeue grant from the scheduler |
| deq_queue_i | input | $clog2(N_PORTS) | Queue named by the grant |
| deq_valid_o | output | 1 | Granted queue held a cell |
| deq_data_o | output | CELL_W | Head cell of the granted queue |
| nonempty_o | output | N_PORTS | One bit per queue, set while the queue holds cells |
| err_o | output | 1 | Sticky flag for a grant to an empty queue |

## Verification
Some properties are checked by assertions on every cycle. The number of cells across all queues plus the free slots always equals DEPTH. Backpressure matches a full buffer. The free list never underflows or overflows. No queue is dequeued while empty. The error flag never clears once set. The bitmap holds steady in any cycle with no accepted transfer. Cell ordering per queue, the data returned for a grant, freedom from head-of-line blocking and same-cycle enqueue and dequeue on one queue can only be shown by the bench scenarios. The bench compares these against its own per-output FIFO model.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int unsigned N_PORTS_DEF = 4;
  localparam int unsigned DEPTH_DEF   = 16;
  localparam int unsigned CELL_W_DEF  = 32;
endpackage

// File: rtl/voq_free_list.sv
module voq_free_list #(
  parameter int unsigned DEPTH = voq_pkg::DEPTH_DEF,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_idx_i,
  output logic [AW-1:0] top_idx_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [AW-1:0] slots_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) slots_q[i] <= AW'(i);
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= FULL_C;
    end else begin
      if (push_i) begin
        slots_q[wr_q] <= push_idx_i;
        wr_q          <= wr_q + 1'b1;
      end
      if (pop_i) rd_q <= rd_q + 1'b1;
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign top_idx_o = slots_q[rd_q];
  assign empty_o   = (count_q == '0);
  assign count_o   = count_q;

  p_free_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);
  p_free_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> count_q != FULL_C);
endmodule

// File: rtl/voq_link_store.sv
module voq_link_store #(
  parameter int unsigned DEPTH  = voq_pkg::DEPTH_DEF,
  parameter int unsigned CELL_W = voq_pkg::CELL_W_DEF,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_idx_i,
  input  logic [CELL_W-1:0] wr_data_i,
  input  logic              lnk_en_i,
  input  logic [AW-1:0]     lnk_idx_i,
  input  logic [AW-1:0]     lnk_val_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [CELL_W-1:0] rd_data_o,
  output logic [AW-1:0]     rd_next_o
);
  logic [CELL_W-1:0] cells_q [DEPTH];
  logic [AW-1:0]     next_q  [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i)  cells_q[wr_idx_i] <= wr_data_i;
    if (lnk_en_i) next_q[lnk_idx_i] <= lnk_val_i;
  end

  assign rd_data_o = cells_q[rd_idx_i];
  assign rd_next_o = next_q[rd_idx_i];
endmodule

// File: rtl/voq_queue_state.sv
module voq_queue_state #(
  parameter int unsigned DEPTH = voq_pkg::DEPTH_DEF,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enq_hit_i,
  input  logic          deq_hit_i,
  input  logic [AW-1:0] slot_i,
  input  logic [AW-1:0] head_next_i,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o,
  output logic [CW-1:0] cnt_o,
  output logic          link_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic          new_head;

  // new cell becomes head when queue is or is about to be empty
  assign new_head = (cnt_q == '0) || (deq_hit_i && cnt_q == ONE_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (deq_hit_i) head_q <= head_next_i;
      if (enq_hit_i) begin
        tail_q <= slot_i;
        if (new_head) head_q <= slot_i;
      end
      cnt_q <= cnt_q + CW'(enq_hit_i) - CW'(deq_hit_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;
  assign link_o = enq_hit_i && !new_head;

  p_deq_only_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_hit_i |-> cnt_q != '0);
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);
endmodule

// File: rtl/voq_input_buffer.sv
module voq_input_buffer #(
  parameter int unsigned N_PORTS = voq_pkg::N_PORTS_DEF,
  parameter int unsigned DEPTH   = voq_pkg::DEPTH_DEF,
  parameter int unsigned CELL_W  = voq_pkg::CELL_W_DEF,
  localparam int unsigned QW = $clog2(N_PORTS),
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enq_valid_i,
  input  logic [QW-1:0]      enq_dest_i,
  input  logic [CELL_W-1:0]  enq_data_i,
  output logic               enq_ready_o,
  input  logic               deq_valid_i,
  input  logic [QW-1:0]      deq_queue_i,
  output logic               deq_valid_o,
  output logic [CELL_W-1:0]  deq_data_o,
  output logic [N_PORTS-1:0] nonempty_o,
  output logic               err_o
);
  localparam int unsigned SW = CW + QW;

  logic [N_PORTS-1:0][AW-1:0] head_w, tail_w;
  logic [N_PORTS-1:0][CW-1:0] cnt_w;
  logic [N_PORTS-1:0]         link_w;
  logic [AW-1:0]              free_idx, rd_next, rd_head;
  logic [CW-1:0]              free_cnt;
  logic                       free_empty, enq_ok, deq_ok, err_q;
  logic [SW-1:0]              stored_sum;

  assign enq_ok  = enq_valid_i && !free_empty;
  assign deq_ok  = deq_valid_i && (cnt_w[deq_queue_i] != '0);
  assign rd_head = head_w[deq_queue_i];

  voq_free_list #(.DEPTH(DEPTH)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (enq_ok),
    .push_i     (deq_ok),
    .push_idx_i (rd_head),
    .top_idx_o  (free_idx),
    .empty_o    (free_empty),
    .count_o    (free_cnt)
  );

  voq_link_store #(.DEPTH(DEPTH), .CELL_W(CELL_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (enq_ok),
    .wr_idx_i  (free_idx),
    .wr_data_i (enq_data_i),
    .lnk_en_i  (|link_w),
    .lnk_idx_i (tail_w[enq_dest_i]),
    .lnk_val_i (free_idx),
    .rd_idx_i  (rd_head),
    .rd_data_o (deq_data_o),
    .rd_next_o (rd_next)
  );

  for (genvar q = 0; q < int'(N_PORTS); q++) begin : g_queue
    voq_queue_state #(.DEPTH(DEPTH)) u_qs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enq_hit_i   (enq_ok && enq_dest_i == QW'(q)),
      .deq_hit_i   (deq_ok && deq_queue_i == QW'(q)),
      .slot_i      (free_idx),
      .head_next_i (rd_next),
      .head_o      (head_w[q]),
      .tail_o      (tail_w[q]),
      .cnt_o       (cnt_w[q]),
      .link_o      (link_w[q])
    );
    assign nonempty_o[q] = (cnt_w[q] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (deq_valid_i && !deq_ok) err_q <= 1'b1;
  end

  assign enq_ready_o = !free_empty;
  assign deq_valid_o = deq_ok;
  assign err_o       = err_q;

  always_comb begin
    stored_sum = '0;
    for (int q = 0; q < int'(N_PORTS); q++) stored_sum = stored_sum + SW'(cnt_w[q]);
  end

  p_cell_conservation_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stored_sum + SW'(free_cnt) == SW'(DEPTH));
  p_ready_tracks_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_sum == SW'(DEPTH)) == !enq_ready_o);
  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_nonempty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enq_ok || deq_ok) |=> $stable(nonempty_o));
  p_deq_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o |-> (deq_valid_i && nonempty_o[deq_queue_i]));
endmodule

// File: tb/voq_input_buffer_test.sv
`timescale 1ns/1ps
module voq_input_buffer_test;
  localparam int N = 4;
  localparam int D = 16;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enq_valid = 1'b0;
  logic [1:0]   enq_dest = '0;
  logic [W-1:0] enq_data = '0;
  logic         deq_valid = 1'b0;
  logic [1:0]   deq_queue = '0;
  logic         enq_ready, deq_valid_o, err;
  logic [W-1:0] deq_data;
  logic [N-1:0] nonempty;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] mq [N][D];
  int mh [N];
  int mc [N];
  int total = 0;
  bit merr = 0;

  always #2 clk = ~clk;

  voq_input_buffer #(.N_PORTS(N), .DEPTH(D), .CELL_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_dest_i(enq_dest), .enq_data_i(enq_data),
    .enq_ready_o(enq_ready),
    .deq_valid_i(deq_valid), .deq_queue_i(deq_queue),
    .deq_valid_o(deq_valid_o), .deq_data_o(deq_data),
    .nonempty_o(nonempty), .err_o(err)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_nonempty();
    logic [N-1:0] v;
    for (int q = 0; q < N; q++) v[q] = (mc[q] != 0);
    return v;
  endfunction

  task automatic step(bit ev, int ed, logic [W-1:0] edat, bit dv, int dq, string tg);
    bit exp_rdy, exp_dv;
    @(negedge clk);
    enq_valid = ev; enq_dest = 2'(ed); enq_data = edat;
    deq_valid = dv; deq_queue = 2'(dq);
    #1;
    exp_rdy = (total < D);
    exp_dv  = dv && (mc[dq] > 0);
    chk(enq_ready == exp_rdy, "R4", enq_ready, exp_rdy);
    chk(nonempty == exp_nonempty(), "R5", nonempty, exp_nonempty());
    chk(deq_valid_o == exp_dv, "R8", deq_valid_o, exp_dv);
    if (exp_dv) chk(deq_data == mq[dq][mh[dq]], tg, deq_data, mq[dq][mh[dq]]);
    chk(err == merr, "R6", err, merr);
    @(posedge clk);
    if (exp_dv) begin
      mh[dq] = (mh[dq] + 1) % D; mc[dq]--; total--;
    end
    if (dv && !exp_dv) merr = 1;
    if (ev && exp_rdy) begin
      mq[ed][(mh[ed] + mc[ed]) % D] = edat; mc[ed]++; total++;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5eed);
    for (int q = 0; q < N; q++) begin mh[q] = 0; mc[q] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(enq_ready == 1'b1, "R1", enq_ready, 1);
    chk(nonempty == '0, "R1", nonempty, 0);
    chk(err == 1'b0, "R1", err, 0);
    chk(deq_valid_o == 1'b0, "R1", deq_valid_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R9 one queue takes every slot, R4 backpressure and ignored enqueue
    for (int i = 0; i < D; i++) step(1, 0, 32'hA000 + i, 0, 0, "R9");
    step(1, 0, 32'hDEAD, 0, 0, "R4");
    step(1, 1, 32'hBEEF, 0, 0, "R4");
    // R7 full buffer: dequeue does not admit a same-cycle enqueue
    step(1, 2, 32'hCAFE, 1, 0, "R7");
    chk(mc[2] == 0, "R7", mc[2], 0);
    for (int i = 1; i < D; i++) step(0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, "R9");

    // R6 grant to empty queue
    step(0, 0, 0, 1, 3, "R6");
    step(0, 0, 0, 0, 0, "R6");

    // R3 blocked head in queue 1 does not stop queue 2
    step(1, 1, 32'h1111, 0, 0, "R3");
    step(1, 1, 32'h1112, 0, 0, "R3");
    step(1, 2, 32'h2221, 0, 0, "R3");
    step(0, 0, 0, 1, 2, "R3");
    step(0, 0, 0, 1, 1, "R3");
    step(0, 0, 0, 1, 1, "R3");

    // R7 same queue, single cell, enqueue and dequeue together
    step(1, 3, 32'h3331, 0, 0, "R7");
    step(1, 3, 32'h3332, 1, 3, "R7");
    step(1, 3, 32'h3333, 1, 3, "R7");
    step(0, 0, 0, 1, 3, "R7");
    step(0, 0, 0, 1, 3, "R7");

    // random traffic, alternating fill-heavy and drain-heavy phases
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 400; i++) begin
        bit ev, dv;
        if (ph % 2 == 0) begin
          ev = ($urandom % 4) != 0; dv = ($urandom % 3) == 0;
        end else begin
          ev = ($urandom % 3) == 0; dv = ($urandom % 4) != 0;
        end
        step(ev, int'($urandom % N), $urandom, dv, int'($urandom % N), "R2");
      end
    end
    // drain everything still stored
    for (int q = 0; q < N; q++)
      while (mc[q] > 0) step(0, 0, 0, 1, q, "R2");
    step(0, 0, 0, 0, 0, "R5");

    @(negedge clk);
    enq_valid = 0; deq_valid = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule